// File: doc/BRIEF.md
# Five-Source Interrupt Enable and Clear Unit

This block gathers interrupt events from five peripheral sources (an external pin, a sample-rate timer, a tempo timer, an asynchronous serial port and a synchronous serial port) and folds them into one interrupt line for a processor. Each source has its own pending latch. An event on the source's input sets the latch. The latch holds until software clears it, and it feeds the shared interrupt line only while that source is enabled.

Software sees a single 16-bit control word. The low byte holds the five enable bits, which can be read and written. The high byte holds five clear strobes at the same bit offsets as the enables. A write with one of these bits set clears that source's latch. These strobes always read back as zero. One write can change the enables and clear latches at once.

Each source input works either as a level pulse or as a rising edge. A parameter mask selects the mode per source. In pulse mode the latch is set in every cycle the input is high. In edge mode it is set only in the cycle the input rises.

Top module: `irq_gate_ctl`

## Requirements
- R1: After reset all enables read as 0, every pending latch is clear and `irq_out` is low, even once every enable is then turned on.
- R2: Control bits 4..0 are enables read back on `reg_rdata[4:0]` one cycle after the write. Bit 4 is the synchronous serial port, bit 3 the asynchronous serial port, bit 2 the tempo timer, bit 1 the sample-rate timer and bit 0 the external source. Without a write the read value does not change.
- R3: Bits 12..8 are clear strobes in the same source order (bit 12 is synchronous serial, bit 8 is external). Bits 12..8, 15..13 and 7..5 always read as 0.
- R4: An event on `src_evt[i]` sets pending latch i at the next clock edge. A source in pulse mode (`EDGE_MASK[i]`=0) is set in any cycle its input is high. A source in edge mode (`EDGE_MASK[i]`=1) is set only when its input was low in the previous cycle and is high now.
- R5: A pending latch holds its value while its source is disabled. Enabling the source later raises `irq_out`.
- R6: Writing 1 to clear bit 8+i resets latch i. Writing 0 to a clear bit leaves its latch unchanged, and other sources are not affected.
- R7: When an event and a clear for the same source meet in one cycle, the latch ends up set.
- R8: `irq_out` is high exactly when some source is both pending and enabled. It is visible in the cycle after the edge that changed either of the two.
- R9: A single write both updates the enables and applies its clear strobes. A write that enables source i and clears it leaves `irq_out` low if no other source is pending and enabled.
- R10: An edge-mode source whose input stays high after being cleared is not set again until the input falls and rises once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data: enables in 4..0, clear strobes in 12..8 |
| reg_rdata | output | 16 | Read data: enables in 4..0, all other bits 0 |
| src_evt | input | 5 | Source event inputs, bit order as the enables |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every pair of a 5-bit pending pattern and a 5-bit enable pattern, and compares `irq_out` with the arithmetic AND-OR of the two. A design with a crossed source mapping or a wrong combine term fails there. Directed cases put an event and a clear in the same cycle, once for a pulse-mode source and once for an edge-mode source. A design where the clear wins would lose the event. Another case clears an edge-mode source while its input stays high. A design that treated the input as a level would set the latch again. Further cases write 0 to clear bits and write all-ones to the unused bits, to catch a clear that spreads to other sources or a strobe that shows up in the read data.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    localparam int NUM_SRC = 5;
    localparam int REG_W   = 16;

    // Bit index of each source inside the enable and clear fields
    typedef enum int unsigned {
        SRC_EXT  = 0,
        SRC_TIM1 = 1,
        SRC_TIM2 = 2,
        SRC_ASER = 3,
        SRC_SSER = 4
    } src_idx_e;
endpackage

// File: rtl/irq_evt_detect.sv
module irq_evt_detect #(
    parameter int               NUM_SRC   = irq_gate_pkg::NUM_SRC,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [NUM_SRC-1:0] hit_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Per source: rising-edge detect or plain level pass-through
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            assign hit_o[i] = evt_i[i] & ~st_q.prev[i];
        end else begin : g_level
            assign hit_o[i] = evt_i[i];
        end
    end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
    parameter int NUM_SRC = irq_gate_pkg::NUM_SRC,
    parameter int REG_W   = irq_gate_pkg::REG_W,
    parameter int CLR_LSB = REG_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wen_i,
    input  logic [NUM_SRC-1:0] wclr_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [REG_W-1:0]   rdata_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (wr_i) begin
            st_d.en = wen_i;
            clr_o   = wclr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o              = '0;
        rdata_o[NUM_SRC-1:0] = st_q.en;
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_SRC = irq_gate_pkg::NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hit_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    // Clear first, then set: an event in the same cycle survives
    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_i) | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irq_gate_ctl.sv
module irq_gate_ctl #(
    parameter int                 NUM_SRC   = irq_gate_pkg::NUM_SRC,
    parameter int                 REG_W     = irq_gate_pkg::REG_W,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] src_evt,
    output logic               irq_out
);
    localparam int CLR_LSB = REG_W / 2;

    logic [NUM_SRC-1:0] hit_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] pend_vec;

    irq_evt_detect #(
        .NUM_SRC   (NUM_SRC),
        .EDGE_MASK (EDGE_MASK)
    ) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (src_evt),
        .hit_o (hit_vec)
    );

    irq_ctl_reg #(
        .NUM_SRC (NUM_SRC),
        .REG_W   (REG_W),
        .CLR_LSB (CLR_LSB)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .wen_i   (reg_wdata[NUM_SRC-1:0]),
        .wclr_i  (reg_wdata[CLR_LSB +: NUM_SRC]),
        .en_o    (en_vec),
        .clr_o   (clr_vec),
        .rdata_o (reg_rdata)
    );

    irq_pend_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit_vec),
        .clr_i  (clr_vec),
        .pend_o (pend_vec)
    );

    assign irq_out = |(pend_vec & en_vec);
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
    parameter int NUM_SRC = irq_gate_pkg::NUM_SRC,
    parameter int REG_W   = irq_gate_pkg::REG_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [REG_W-1:0]   reg_rdata,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] hit_vec,
    input logic [NUM_SRC-1:0] pend_vec
);
    localparam int CLR_LSB = REG_W / 2;

    // R2
    enable_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[NUM_SRC-1:0] == $past(reg_wdata[NUM_SRC-1:0]));

    // R2
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(reg_rdata));

    // R8
    irq_combine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == ((pend_vec & reg_rdata[NUM_SRC-1:0]) != '0));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // R4, R7
        event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[i] |=> pend_vec[i]);

        // R6
        clear_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_wdata[CLR_LSB+i] && !hit_vec[i]) |=> !pend_vec[i]);

        // R5
        pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit_vec[i] && !(reg_wr && reg_wdata[CLR_LSB+i])) |=> $stable(pend_vec[i]));
    end
endmodule

bind irq_gate_ctl irq_gate_chk #(
    .NUM_SRC (NUM_SRC),
    .REG_W   (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .hit_vec   (hit_vec),
    .pend_vec  (pend_vec)
);

// File: tb/sim_irq_gate_ctl.sv
`timescale 1ns/1ps
module sim_irq_gate_ctl;
    localparam int N = 5;
    localparam logic [N-1:0] EDGES = 5'b01010;   // sources 1 and 3 edge mode

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [N-1:0] src_evt = '0;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_gate_ctl #(.EDGE_MASK(EDGES)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_evt   (src_evt),
        .irq_out   (irq_out)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus; returns at the negedge after the capturing edge
    task automatic step(input logic wr, input logic [15:0] wd, input logic [N-1:0] evt);
        @(negedge clk);
        reg_wr    = wr;
        reg_wdata = wd;
        src_evt   = evt;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    // Reveal pending latches through the enables and irq_out, one at a time
    task automatic probe(input logic [N-1:0] exp, input string req);
        for (int i = 0; i < N; i++) begin
            step(1'b1, 16'(1 << i), src_evt);
            check({15'b0, irq_out}, {15'b0, exp[i]}, req);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(reg_rdata, 16'h0000, "R1");
        check({15'b0, irq_out}, 16'h0, "R1");
        step(1'b1, 16'h001F, '0);
        check({15'b0, irq_out}, 16'h0, "R1");

        // R3: strobe and unused bits read zero
        step(1'b1, 16'hFFFF, '0);
        check(reg_rdata, 16'h001F, "R3");
        step(1'b1, 16'hFFE0, '0);
        check(reg_rdata, 16'h0000, "R3");
        // R2: no write keeps value
        step(1'b1, 16'h0015, '0);
        step(1'b0, 16'h0000, '0);
        check(reg_rdata, 16'h0015, "R2");

        // R8 / R2 / R4: exhaustive pending x enable sweep
        for (int e = 0; e < 32; e++) begin
            for (int p = 0; p < 32; p++) begin
                step(1'b1, 16'h1F00, '0);
                step(1'b0, 16'h0, 5'(p));
                step(1'b0, 16'h0, '0);
                step(1'b1, 16'(e), '0);
                check({15'b0, irq_out}, {15'b0, ((p & e) != 0)}, "R8");
                check(reg_rdata, 16'(e), "R2");
            end
        end

        // R5: pending survives while disabled
        step(1'b1, 16'h1F00, '0);
        step(1'b0, 16'h0, 5'b00100);
        step(1'b0, 16'h0, '0);
        repeat (4) step(1'b0, 16'h0, '0);
        check({15'b0, irq_out}, 16'h0, "R5");
        step(1'b1, 16'h0004, '0);
        check({15'b0, irq_out}, 16'h1, "R5");

        // R6: selective clear, zero bits leave latches alone
        step(1'b1, 16'h1F00, '0);
        step(1'b0, 16'h0, 5'b11111);
        step(1'b0, 16'h0, '0);
        step(1'b1, 16'h0500, '0);
        probe(5'b11010, "R6");

        // R9: enable and clear in one write
        step(1'b1, 16'h1F00, '0);
        step(1'b0, 16'h0, 5'b10000);
        step(1'b0, 16'h0, '0);
        step(1'b1, 16'h1010, '0);
        check({15'b0, irq_out}, 16'h0, "R9");
        check(reg_rdata, 16'h0010, "R9");

        // R7: event and clear same cycle, pulse source 0 and edge source 3
        step(1'b1, 16'h1F00, '0);
        step(1'b1, 16'h0900, 5'b01001);
        step(1'b0, 16'h0, '0);
        probe(5'b01001, "R7");

        // R10 / R7: held-high inputs cleared mid-hold (source 1 edge, source 2 pulse)
        step(1'b1, 16'h1F00, '0);
        step(1'b0, 16'h0, 5'b00110);
        step(1'b1, 16'h0600, 5'b00110);
        step(1'b0, 16'h0, 5'b00110);
        probe(5'b00100, "R10");
        step(1'b0, 16'h0, '0);
        // R4: edge source fires again after a fresh rise
        step(1'b0, 16'h0, 5'b00010);
        step(1'b0, 16'h0, '0);
        probe(5'b00110, "R4");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule